// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a clocked binary up-counter built from 4-bit slices. Each slice can be cleared or preset on a clock edge, and it counts only when two enables agree. The first enable, `en_p`, goes to every slice. The second, `en_t`, enters the lowest slice only. Each higher slice receives the carry of the slice below it in place of `en_t`.

A slice's carry is high only while its incoming trickle enable is high and all four of its bits are one. That carry is the enable for the next slice, so a wide counter advances in a single edge with no ripple clocking between slices. The carry of the top slice is brought out as a terminal-count flag for joining further counters.

Clear, load and data act on all slices at the same time. Priority is fixed: clear first, then load, then count.

Top module: `casc_counter`

## Requirements
- R1: When `rst_n` is 0 at a rising edge of `clk`, `count` becomes 0 on that edge, whatever `load_n`, `en_p`, `en_t` and `din` are.
- R2: When `rst_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `din` on that edge, whatever `en_p` and `en_t` are.
- R3: When `rst_n`, `load_n`, `en_p` and `en_t` are all 1 at a rising edge, `count` increases by one, modulo 2^(4·SLICES).
- R4: When `rst_n` and `load_n` are 1 and `en_p` is 0 at a rising edge, `count` holds its value.
- R5: When `rst_n` and `load_n` are 1 and `en_t` is 0 at a rising edge, `count` holds its value.
- R6: `slice_carry[i]` is combinational. It is 1 exactly when `en_t` is 1 and bits 0 through 4·i+3 of `count` are all 1. Bit i of `slice_carry` belongs to the slice holding `count[4i+3:4i]`.
- R7: `term_cnt` is 1 exactly when `en_t` is 1 and every bit of `count` is 1. It does not depend on `en_p`.
- R8: A slice that wraps from 15 to 0 makes the slice above it advance by one on the same edge. A full count of all ones wraps to 0.
- R9: The following sequence produces the stated values: clear gives 0. Loading the low slice with 12 (with the upper slices all ones) gives 12. Counting then runs through 13, 14, 15, 0, 1, 2 in the low slice. Dropping an enable after that leaves the value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable shared by all slices |
| en_t | input | 1 | Trickle enable into the lowest slice; also gates the carries |
| din | input | 4·SLICES | Preset word |
| count | output | 4·SLICES | Counter value |
| slice_carry | output | SLICES | Carry out of each slice |
| term_cnt | output | 1 | Carry out of the top slice |

## Verification
A vector table first drives the clear-load-count-inhibit sequence. It starts with the low slice at twelve and the upper slice at all ones, so one run shows the low-slice wrap, the full-width wrap and the carry chain.

Further vectors set clear and load together, and load with both enables low, to separate the priority order from a design that lets enables interfere. Other vectors hold the count at all ones with `en_t` low and then with `en_p` low. These show that the carries follow the trickle enable alone.

A random phase then compares count and carries against a bench model on every cycle. This catches wrong carry widths or chaining that the fixed vectors might miss.

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int SLICES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_n,
  input  logic                  en_p,
  input  logic                  en_t,
  input  logic [4*SLICES-1:0]   din,
  output logic [4*SLICES-1:0]   count,
  output logic [SLICES-1:0]     slice_carry,
  output logic                  term_cnt
);
  localparam int SW = 4;
  localparam logic [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};

  logic [SLICES:0] tchain;
  assign tchain[0] = en_t;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    logic [SW-1:0] nib_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                  nib_q <= '0;
      else if (!load_n)            nib_q <= din[i*SW +: SW];
      else if (en_p && tchain[i])  nib_q <= nib_q + ONE;
    end

    assign count[i*SW +: SW] = nib_q;
    assign slice_carry[i]    = tchain[i] & (&nib_q);
    assign tchain[i+1]       = slice_carry[i];
  end

  assign term_cnt = tchain[SLICES];
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int SLICES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load_n,
  input logic                en_p,
  input logic                en_t,
  input logic [4*SLICES-1:0] din,
  input logic [4*SLICES-1:0] count,
  input logic [SLICES-1:0]   slice_carry,
  input logic                term_cnt
);
  localparam int W = 4*SLICES;
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  AST_CLEAR: assert property (@(posedge clk) disable iff (!started)
    !rst_n |=> count == '0);  // R1
  AST_LOAD: assert property (@(posedge clk) disable iff (!started)
    (rst_n && !load_n) |=> count == $past(din));  // R2
  AST_INCREMENT: assert property (@(posedge clk) disable iff (!started)
    (rst_n && load_n && en_p && en_t) |=> count == W'($past(count) + 1'b1));  // R3
  AST_HOLD_P: assert property (@(posedge clk) disable iff (!started)
    (rst_n && load_n && !en_p) |=> $stable(count));  // R4
  AST_HOLD_T: assert property (@(posedge clk) disable iff (!started)
    (rst_n && load_n && !en_t) |=> $stable(count));  // R5
  AST_LOW_CARRY: assert property (@(posedge clk) disable iff (!started)
    slice_carry[0] == (en_t && (&count[3:0])));  // R6
  AST_TERM: assert property (@(posedge clk) disable iff (!started)
    term_cnt == (en_t && (&count)));  // R7
endmodule

bind casc_counter casc_counter_chk #(.SLICES(SLICES)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
  .din(din), .count(count), .slice_carry(slice_carry), .term_cnt(term_cnt)
);

// File: tb/casc_counter_tb.sv
`timescale 1ns/1ps
module casc_counter_tb;
  localparam int SLICES = 2;
  localparam int W = 4*SLICES;

  logic clk = 1'b0;
  logic rst_n, load_n, en_p, en_t;
  logic [W-1:0] din;
  logic [W-1:0] count;
  logic [SLICES-1:0] slice_carry;
  logic term_cnt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  casc_counter #(.SLICES(SLICES)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .count(count), .slice_carry(slice_carry), .term_cnt(term_cnt)
  );

  // {rst_n, load_n, en_p, en_t, din[7:0], exp_count[7:0], exp_carry[1:0]}
  localparam logic [21:0] VEC [15] = '{
    {4'b0011, 8'hAA, 8'h00, 2'b00},  // R1 clear beats load
    {4'b1000, 8'hFC, 8'hFC, 2'b00},  // R2 R9 load twelve, enables low
    {4'b1111, 8'h00, 8'hFD, 2'b00},  // R3 R9
    {4'b1111, 8'h00, 8'hFE, 2'b00},  // R9
    {4'b1111, 8'h00, 8'hFF, 2'b11},  // R9 R7
    {4'b1111, 8'h00, 8'h00, 2'b00},  // R8 R9 full wrap
    {4'b1111, 8'h00, 8'h01, 2'b00},  // R9
    {4'b1111, 8'h00, 8'h02, 2'b00},  // R9
    {4'b1101, 8'h00, 8'h02, 2'b00},  // R4 R9 inhibit
    {4'b1110, 8'h00, 8'h02, 2'b00},  // R5
    {4'b1011, 8'h0F, 8'h0F, 2'b01},  // R6 low slice carry only
    {4'b1111, 8'h00, 8'h10, 2'b00},  // R8 carry into upper slice
    {4'b1010, 8'hFF, 8'hFF, 2'b00},  // R7 en_t low gates carries
    {4'b1110, 8'h00, 8'hFF, 2'b00},  // R5
    {4'b1101, 8'h00, 8'hFF, 2'b11}   // R4 R7 carry ignores en_p
  };

  task automatic check(string req, logic [W-1:0] exp_c, logic [SLICES-1:0] exp_k);
    checks++;
    if (count !== exp_c || slice_carry !== exp_k || term_cnt !== exp_k[SLICES-1]) begin
      errors++;
      $display("FAIL %s: count=%h carry=%b tc=%b expected count=%h carry=%b tc=%b",
               req, count, slice_carry, term_cnt, exp_c, exp_k, exp_k[SLICES-1]);
    end
  endtask

  function automatic logic [SLICES-1:0] carries(logic [W-1:0] c, logic t);
    logic [SLICES-1:0] k;
    for (int i = 0; i < SLICES; i++) k[i] = t && ((c | ~((W'(1) << (4*(i+1))) - W'(1))) == '1);
    return k;
  endfunction

  task automatic step(logic r, logic l, logic p, logic t, logic [W-1:0] d);
    rst_n = r; load_n = l; en_p = p; en_t = t; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] model;
    rst_n = 1'b0; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = '0;
    @(negedge clk);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h5A);
    check("R1 reset state", 8'h00, 2'b00);

    for (int v = 0; v < 15; v++) begin
      step(VEC[v][21], VEC[v][20], VEC[v][19], VEC[v][18], VEC[v][17:10]);
      check($sformatf("R1-R9 vector %0d", v), VEC[v][9:2], VEC[v][1:0]);
    end

    // R1 clear with all other inputs active
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h77);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h33);
    check("R1 clear over load and count", 8'h00, 2'b00);
    // R2 load over count
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'hEF);
    check("R2 load over count", 8'hEF, 2'b01);
    // R8 low wrap carries into upper slice
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    check("R8 slice wrap", 8'hF0, 2'b00);

    model = count;
    for (int n = 0; n < 400; n++) begin
      logic r, l, p, t;
      logic [W-1:0] d;
      r = ($urandom_range(0, 19) != 0);
      l = ($urandom_range(0, 9) != 0);
      p = ($urandom_range(0, 3) != 0);
      t = ($urandom_range(0, 3) != 0);
      d = W'($urandom);
      if (!r) model = '0;
      else if (!l) model = d;
      else if (p && t) model = model + 1'b1;
      step(r, l, p, t, d);
      check("R3 R6 random", model, carries(model, t));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule